// File: doc/BRIEF.md
# Masked Bus Access Comparator

This block watches one CPU memory interface: an address bus, a data bus, and separate read and write strobes. It compares either the address or the data of each access against a programmed reference value. A per-bit mask marks some positions as don't-care, so one unit can cover an aligned window of addresses. An example is a guard band of sixteen words at the top of a stack.

The match can be limited to read accesses, to write accesses, or to either direction. A qualified match has two results. It produces a single-cycle event pulse, which downstream sequencing logic uses to track ordered chains of bus events. It also sets a sticky flag, which drives an interrupt output until software clears it.

A small register port holds the reference, the mask, a control word and the status. The control word contains the direction mode, the compare source, a global enable and an interrupt enable. Every compare result is registered once, so the event appears one clock after the access that caused it.

Top module: `bus_match_unit`

## Requirements
- R1: An access matches when `((value ^ reference) & ~mask) == 0` over all compare bits. A mask bit of 1 makes that bit position don't-care.
- R2: Control bit 2 selects the compared value: 0 compares `bus_addr`, 1 compares `bus_data`. Both are zero-extended to the compare width.
- R3: Control bits [1:0] give the direction mode. 00 never matches, 01 matches only when `bus_rd` is high, 10 only when `bus_wr` is high, and 11 when either strobe is high. No match is possible in a cycle with neither strobe high.
- R4: `match_evt` is high for exactly the cycle after each qualifying access. Back-to-back qualifying accesses give back-to-back high cycles.
- R5: The sticky flag is set in the same clock as the event and stays set. It is cleared by writing offset 3 with data bit 0 = 1. Writing 0 to that bit has no effect. A match in the same cycle as the clear leaves the flag set.
- R6: `irq` equals the sticky flag AND control bit 4 (interrupt enable). It follows the enable bit without touching the flag.
- R7: When control bit 3 (global enable) is 0, no event is produced and the flag is never set.
- R8: A write to offset 0 (reference), 1 (mask) or 2 (control) takes effect from the next clock. An access in the same cycle as the write is judged with the old settings.
- R9: After reset all registers, `match_evt`, `irq` and `cfg_rdata` are zero. `cfg_rdata` returns, one clock later, the register at the `cfg_addr` presented: reference, mask, control in bits [4:0], or the flag in bit 0 for offset 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Address of the monitored access |
| bus_data | input | DATA_W | Data of the monitored access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | CMP_W | Register write data |
| cfg_rdata | output | CMP_W | Registered read data for the offset of the previous cycle |
| match_evt | output | 1 | One-cycle event pulse per qualified match |
| irq | output | 1 | Sticky flag gated by the interrupt enable |

## Verification
A directed guard-window case uses reference 0x99FF0 with the low 4 bits masked and the mode set to writes only. Writes inside the window, a read inside it, and writes just outside it on either side separate correct masking from an exact compare or a missing direction check. Further directed cases cover four things: the same-cycle reconfiguration, the clear-versus-set collision, the global-enable cut-off, and flipping the interrupt enable with a set flag. These separate register timing and flag priority from the compare path. Constrained random traffic follows. Its bus values are biased to land inside and just outside the masked window, with all four modes, both compare sources, and occasional rewrites of every register. Each cycle is compared against a bench model of the requirements.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_RD  = 2'b01,
    MODE_WR  = 2'b10,
    MODE_ANY = 2'b11
  } bmu_mode_e;

  typedef enum logic [1:0] {
    OFS_REF  = 2'd0,
    OFS_MASK = 2'd1,
    OFS_CTL  = 2'd2,
    OFS_STAT = 2'd3
  } bmu_ofs_e;

  // Packed control word: ien = bit 4, gen = bit 3, src = bit 2, mode = bits [1:0]
  typedef struct packed {
    logic      ien;
    logic      gen;
    logic      src;
    bmu_mode_e mode;
  } bmu_ctl_t;

  localparam int CTL_W = $bits(bmu_ctl_t);

endpackage

// File: rtl/bmu_regs.sv
module bmu_regs
  import bmu_pkg::*;
#(
  parameter int CMP_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CMP_W-1:0] cfg_wdata,
  input  logic             flag_q,
  output logic [CMP_W-1:0] ref_q,
  output logic [CMP_W-1:0] mask_q,
  output bmu_ctl_t         ctl_q,
  output logic             clr_req,
  output logic [CMP_W-1:0] rdata_q
);

  logic [CMP_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      mask_q <= '0;
      ctl_q  <= '0;
    end else if (cfg_we) begin
      case (bmu_ofs_e'(cfg_addr))
        OFS_REF:  ref_q  <= cfg_wdata;
        OFS_MASK: mask_q <= cfg_wdata;
        OFS_CTL:  ctl_q  <= bmu_ctl_t'(cfg_wdata[CTL_W-1:0]);
        default:  ;
      endcase
    end
  end

  // Write-one-to-clear request for the sticky flag
  assign clr_req = cfg_we && (bmu_ofs_e'(cfg_addr) == OFS_STAT) && cfg_wdata[0];

  always_comb begin
    case (bmu_ofs_e'(cfg_addr))
      OFS_REF:  rd_mux = ref_q;
      OFS_MASK: rd_mux = mask_q;
      OFS_CTL:  rd_mux = {{(CMP_W-CTL_W){1'b0}}, ctl_q};
      default:  rd_mux = {{(CMP_W-1){1'b0}}, flag_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

endmodule

// File: rtl/bmu_match.sv
module bmu_match
  import bmu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CMP_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [CMP_W-1:0]  ref_v,
  input  logic [CMP_W-1:0]  mask_v,
  input  bmu_ctl_t          ctl,
  output logic              evt_q
);

  logic [CMP_W-1:0] addr_ext;
  logic [CMP_W-1:0] data_ext;
  logic [CMP_W-1:0] sel_v;
  logic [CMP_W-1:0] diff;
  logic             dir_ok;
  logic             hit;

  // Zero-extend each source to the compare width
  for (genvar i = 0; i < CMP_W; i++) begin : g_ext
    if (i < ADDR_W) begin : g_a
      assign addr_ext[i] = bus_addr[i];
    end else begin : g_az
      assign addr_ext[i] = 1'b0;
    end
    if (i < DATA_W) begin : g_d
      assign data_ext[i] = bus_data[i];
    end else begin : g_dz
      assign data_ext[i] = 1'b0;
    end
  end

  always_comb begin
    sel_v = ctl.src ? data_ext : addr_ext;
    diff  = (sel_v ^ ref_v) & ~mask_v;
    case (ctl.mode)
      MODE_RD:  dir_ok = bus_rd;
      MODE_WR:  dir_ok = bus_wr;
      MODE_ANY: dir_ok = bus_rd | bus_wr;
      default:  dir_ok = 1'b0;
    endcase
    hit = ctl.gen & dir_ok & ~(|diff);
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= hit;
  end

endmodule

// File: rtl/bmu_flag.sv
module bmu_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_in,
  input  logic clr_in,
  output logic flag_q
);

  // A set in the same cycle as a clear wins, so no event is lost
  always_ff @(posedge clk) begin
    if (rst)         flag_q <= 1'b0;
    else if (set_in) flag_q <= 1'b1;
    else if (clr_in) flag_q <= 1'b0;
  end

endmodule

// File: rtl/bus_match_unit.sv
module bus_match_unit
  import bmu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int CMP_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CMP_W-1:0]  cfg_wdata,
  output logic [CMP_W-1:0]  cfg_rdata,
  output logic              match_evt,
  output logic              irq
);

  logic [CMP_W-1:0] ref_q;
  logic [CMP_W-1:0] mask_q;
  bmu_ctl_t         ctl_q;
  logic             clr_req;
  logic             flag_q;
  logic             hit_d;
  logic [1:0]       ctl_mode;
  logic             ctl_gen;

  assign ctl_mode = ctl_q.mode;
  assign ctl_gen  = ctl_q.gen;

  bmu_regs #(.CMP_W(CMP_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .flag_q   (flag_q),
    .ref_q    (ref_q),
    .mask_q   (mask_q),
    .ctl_q    (ctl_q),
    .clr_req  (clr_req),
    .rdata_q  (cfg_rdata)
  );

  bmu_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_match (
    .clk     (clk),
    .rst     (rst),
    .bus_addr(bus_addr),
    .bus_data(bus_data),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .ref_v   (ref_q),
    .mask_v  (mask_q),
    .ctl     (ctl_q),
    .evt_q   (match_evt)
  );

  // The flag sees the same registered hit as the event: both move on one edge
  bmu_flag u_flag (
    .clk   (clk),
    .rst   (rst),
    .set_in(hit_d),
    .clr_in(clr_req),
    .flag_q(flag_q)
  );

  assign hit_d = u_match.hit;
  assign irq   = flag_q & ctl_q.ien;

endmodule

// File: rtl/bmu_checker.sv
module bmu_checker (
  input logic       clk,
  input logic       rst,
  input logic       evt,
  input logic       flag,
  input logic       irq,
  input logic [1:0] mode,
  input logic       gen,
  input logic       clr,
  input logic       acc_rd,
  input logic       acc_wr
);

  p_evt_needs_access_r3: assert property (@(posedge clk) disable iff (rst)
    evt |-> ($past(acc_rd) | $past(acc_wr)));

  p_mode_off_silent_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'b00) |-> !evt);

  p_rd_only_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'b01 && !$past(acc_rd)) |-> !evt);

  p_evt_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    evt |-> flag);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(flag) && !$past(clr)) |-> flag);

  p_flag_rise_has_evt_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> evt);

  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  p_disabled_silent_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(gen) |-> !evt);

endmodule

bind bus_match_unit bmu_checker u_chk (
  .clk   (clk),
  .rst   (rst),
  .evt   (match_evt),
  .flag  (flag_q),
  .irq   (irq),
  .mode  (ctl_mode),
  .gen   (ctl_gen),
  .clr   (clr_req),
  .acc_rd(bus_rd),
  .acc_wr(bus_wr)
);

// File: tb/bus_match_unit_bench.sv
`timescale 1ns/1ps
module bus_match_unit_bench;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 32;
  localparam real HALF = 2.0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [CW-1:0] cfg_rdata;
  logic          match_evt;
  logic          irq;

  always #(HALF) clk = ~clk;

  bus_match_unit #(.ADDR_W(AW), .DATA_W(DW)) u_bus_match_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .match_evt(match_evt), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  string cur_tag = "R9";

  // Bench model of the requirements
  logic [CW-1:0] m_ref = '0, m_mask = '0, m_rdata = '0;
  logic [4:0]    m_ctl = '0;
  logic          m_flag = 1'b0, m_evt = 1'b0;

  function automatic logic fn_hit(input logic [CW-1:0] a, input logic [CW-1:0] d,
                                  input logic rd, input logic wr);
    logic [CW-1:0] v;
    logic dir;
    v = m_ctl[2] ? d : a;                       // R2 source select
    case (m_ctl[1:0])                           // R3 direction mode
      2'b01:   dir = rd;
      2'b10:   dir = wr;
      2'b11:   dir = rd | wr;
      default: dir = 1'b0;
    endcase
    return m_ctl[3] && dir && (((v ^ m_ref) & ~m_mask) == '0);  // R1, R7
  endfunction

  function automatic logic [CW-1:0] fn_read(input logic [1:0] ofs);
    case (ofs)
      2'd0:    return m_ref;
      2'd1:    return m_mask;
      2'd2:    return {{(CW-5){1'b0}}, m_ctl};
      default: return {{(CW-1){1'b0}}, m_flag};
    endcase
  endfunction

  task automatic chk(input string what, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  // One bus/config cycle: inputs set at negedge, model updated at posedge, checked at next negedge
  task automatic cyc(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic rd,
                     input logic wr, input logic we, input logic [1:0] ofs,
                     input logic [CW-1:0] wd);
    logic h, clr;
    bus_addr = a; bus_data = d; bus_rd = rd; bus_wr = wr;
    cfg_we = we; cfg_addr = ofs; cfg_wdata = wd;
    @(posedge clk);
    h = fn_hit(a, d, rd, wr);
    clr = we && ofs == 2'd3 && wd[0];
    m_rdata = fn_read(ofs);                     // R9 readback uses pre-write contents
    m_evt = h;                                  // R4
    m_flag = h | (m_flag & ~clr);               // R5 set wins over clear
    if (we) begin                               // R8 new settings apply from next clock
      case (ofs)
        2'd0: m_ref = wd;
        2'd1: m_mask = wd;
        2'd2: m_ctl = wd[4:0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk("match_evt", {{(CW-1){1'b0}}, match_evt}, {{(CW-1){1'b0}}, m_evt});
    chk("irq", {{(CW-1){1'b0}}, irq}, {{(CW-1){1'b0}}, m_flag & m_ctl[4]});  // R6
    chk("cfg_rdata", cfg_rdata, m_rdata);
  endtask

  task automatic wr_reg(input logic [1:0] ofs, input logic [CW-1:0] wd);
    cyc('0, '0, 1'b0, 1'b0, 1'b1, ofs, wd);
  endtask

  task automatic acc(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic rd, input logic wr);
    cyc(a, d, rd, wr, 1'b0, 2'd3, '0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    cur_tag = "R9";
    chk("evt after reset", {{(CW-1){1'b0}}, match_evt}, '0);
    chk("irq after reset", {{(CW-1){1'b0}}, irq}, '0);
    chk("rdata after reset", cfg_rdata, '0);
    for (int o = 0; o < 4; o++) cyc('0, '0, 1'b0, 1'b0, 1'b0, o[1:0], '0);

    // R1/R3: guard window 0x99FF0..0x99FFF, writes only, gen+ien
    cur_tag = "R1";
    wr_reg(2'd0, 32'h0009_9FF0);
    wr_reg(2'd1, 32'h0000_000F);
    wr_reg(2'd2, 32'h0000_001A);               // ien=1 gen=1 src=addr mode=10
    acc(32'h0009_9FF7, 32'h1234, 1'b0, 1'b1);  // inside: hit
    acc(32'h0009_9FFF, 32'h0, 1'b0, 1'b1);     // top edge: hit
    acc(32'h0009_A000, 32'h0, 1'b0, 1'b1);     // just above: miss
    acc(32'h0009_9FEF, 32'h0, 1'b0, 1'b1);     // just below: miss
    cur_tag = "R3";
    acc(32'h0009_9FF0, 32'h0, 1'b1, 1'b0);     // read in write-only mode: miss
    acc(32'h0009_9FF0, 32'h0, 1'b0, 1'b0);     // no strobe: miss
    cur_tag = "R4";
    acc(32'h0009_9FF1, 32'h0, 1'b0, 1'b1);     // back-to-back events
    acc(32'h0009_9FF2, 32'h0, 1'b0, 1'b1);
    acc(32'h0000_0000, 32'h0, 1'b0, 1'b0);
    cur_tag = "R5";
    cyc('0, '0, 1'b0, 1'b0, 1'b1, 2'd3, 32'h0);          // write 0: no clear
    cyc('0, '0, 1'b0, 1'b0, 1'b1, 2'd3, 32'h1);          // clear
    acc('0, '0, 1'b0, 1'b0);
    acc(32'h0009_9FF3, 32'h0, 1'b0, 1'b1);               // set again
    cyc(32'h0009_9FF3, '0, 1'b0, 1'b1, 1'b1, 2'd3, 32'h1); // clear collides with match
    acc('0, '0, 1'b0, 1'b0);
    cur_tag = "R6";
    wr_reg(2'd2, 32'h0000_000A);               // ien off, flag kept
    acc('0, '0, 1'b0, 1'b0);
    wr_reg(2'd2, 32'h0000_001A);
    acc('0, '0, 1'b0, 1'b0);
    cur_tag = "R7";
    cyc('0, '0, 1'b0, 1'b0, 1'b1, 2'd3, 32'h1);
    wr_reg(2'd2, 32'h0000_0013);               // gen off, mode any
    acc(32'h0009_9FF4, '0, 1'b1, 1'b1);
    acc(32'h0009_9FF5, '0, 1'b0, 1'b1);
    cur_tag = "R8";
    wr_reg(2'd2, 32'h0000_001B);               // gen on, any
    cyc(32'h0000_5550, '0, 1'b1, 1'b0, 1'b1, 2'd0, 32'h0000_5550); // old ref: miss
    acc(32'h0000_5553, '0, 1'b1, 1'b0);        // new ref: hit
    cyc(32'h0000_5561, '0, 1'b1, 1'b0, 1'b1, 2'd1, 32'h0000_00FF); // old mask: miss
    acc(32'h0000_5561, '0, 1'b1, 1'b0);        // new mask: hit
    cur_tag = "R2";
    wr_reg(2'd2, 32'h0000_001F);               // src=data, any
    acc(32'h0000_0000, 32'h0000_55AB, 1'b1, 1'b0);  // data in window: hit
    acc(32'h0000_5550, 32'h0000_0000, 1'b1, 1'b0);  // address only: miss
    cur_tag = "R9";
    for (int o = 0; o < 4; o++) cyc('0, '0, 1'b0, 1'b0, 1'b0, o[1:0], '0);

    // Random traffic (R1..R9 all compared each cycle)
    cur_tag = "R1";
    for (int n = 0; n < 6000; n++) begin
      logic [CW-1:0] wd, v;
      logic we;
      logic [1:0] ofs;
      we  = ($urandom_range(15) == 0);
      ofs = 2'($urandom_range(3));
      wd  = $urandom();
      if (we && ofs == 2'd1) wd = wd & 32'h0000_00FF;
      if (we && ofs == 2'd2 && $urandom_range(3) != 0) wd[3] = 1'b1;
      if (we && ofs == 2'd3 && $urandom_range(3) != 0) wd[0] = 1'b0;
      v = ($urandom_range(1) == 0) ? (m_ref ^ ($urandom() & (m_mask | 32'h100))) : $urandom();
      cyc(v, ($urandom_range(1) == 0) ? v : $urandom(), 1'($urandom_range(1)),
          1'($urandom_range(1)), we, ofs, wd);
    end
    finish_run();
  end

endmodule